// File: doc/BRIEF.md
# Four-Slot ADC Conversion Sequencer

This block controls an external eight-input, 8-bit analog-to-digital converter from a small CPU register bus. Software turns the converter on through an option register, waits for it to settle, and then writes a control register. Each write to the control register starts a group of four conversions. In single-channel mode all four conversions sample one input. In bank mode they step through four neighbouring inputs in ascending order. The k-th conversion of a group is stored in result slot k, and a done flag in the control register rises once all four slots hold fresh values.

Each conversion lasts a fixed number of clock cycles. The first part of that time is a sampling window, during which the block holds the chosen channel on a select output and raises a sample strobe. The converter's output code is captured at the last cycle of the window and is written to its slot when the conversion ends. A scan bit makes the group repeat without end. In that case the done flag stays set after the first full pass and the slots keep updating in place.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every readable address (0 control, 1 to 4 result slots, 5 option) reads 0.
- R2: A control write starts no conversion while option bit 7 (power) is 0, or before SETTLE_CYC cycles have passed since power was switched on. The done flag then stays 0, the sample strobe stays low and the result slots keep their values.
- R3: With control bit 4 (bank mode) at 0, all four conversions sample the channel given by control bits 2..0. Bit 3 has no effect on the channel.
- R4: With control bit 4 at 1, control bit 2 picks the bank (0: channels 0 to 3, 1: channels 4 to 7). The bank is converted in ascending channel order, and control bits 1..0 have no effect.
- R5: The k-th conversion of a group (k = 1..4) is written to the result slot at address k, and to no other slot.
- R6: Each conversion takes CONV_CYC (32) cycles. The done flag (control bit 7) reads 0 in the cycles up to and including 4*CONV_CYC-1 after the starting write edge, and reads 1 from cycle 4*CONV_CYC.
- R7: The sample strobe is high for the first SAMPLE_CYC (12) cycles of every conversion. The stored code is the converter input during the last cycle of that window. Changes to the input after that cycle do not reach that conversion's result.
- R8: A control write during a running group clears the done flag at once, abandons the group and starts a new group from slot 1.
- R9: With control bit 5 (scan) at 0, the block runs exactly one group per write. After that the sample strobe stays low and the done flag stays 1.
- R10: With control bit 5 at 1, groups repeat back to back. The done flag stays 1 after the first pass, and later inputs appear in the slots.
- R11: The control register reads back bit 7 as the done flag, bit 6 as 0 and bits 5..0 as last written. Bits 7 and 6 of a control write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| conv_chan | output | 3 | Channel selected for the current conversion |
| conv_sample | output | 1 | High during the sampling window |
| conv_data | input | 8 | Output code of the external converter |

## Verification
Every result in this block is due at a fixed cycle offset from the write edge that starts a group. The first conversion's code is captured at the end of cycle 11, its slot is written at the end of cycle 31, and the done flag first reads 1 in cycle 128. The bench counts clock edges from the write and reads the done flag in cycle 127 and again in cycle 128, so an early or late flag is caught. It changes converter inputs in cycles 12 and 43 to show exactly which cycle the capture uses. It also counts sample-strobe cycles, expecting 48 per group and none once a single group has finished or while power is off.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int BYTE_W  = 8;
    localparam int N_SLOTS = 4;
    localparam int CHAN_W  = 3;
    localparam int SLOT_W  = $clog2(N_SLOTS);

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_OPT  = 3'd5;

    typedef struct packed {
        logic       scan;
        logic       bank_mode;
        logic [3:0] sel;
    } ctrl_t;

    function automatic logic [CHAN_W-1:0] pick_chan(ctrl_t c, logic [SLOT_W-1:0] slot);
        if (c.bank_mode)
            return {c.sel[2], slot};
        return c.sel[2:0];
    endfunction

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int CONV_CYC   = 32,
    parameter int SAMPLE_CYC = 12,
    localparam int CYC_W     = $clog2(CONV_CYC)
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic sample,
    output logic capture,
    output logic last
);

    logic [CYC_W-1:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cyc_q <= '0;
        else if (run)
            cyc_q <= last ? '0 : cyc_q + 1'b1;
    end

    always_comb begin
        sample  = run && (cyc_q < CYC_W'(SAMPLE_CYC));
        capture = run && (cyc_q == CYC_W'(SAMPLE_CYC - 1));
        last    = run && (cyc_q == CYC_W'(CONV_CYC - 1));
    end

    a_r7_window_length: assert property (@(posedge clk) disable iff (rst)
        ($fell(sample) && run && !$past(restart)) |-> (cyc_q == CYC_W'(SAMPLE_CYC)));

    a_r6_wraps_after_last: assert property (@(posedge clk) disable iff (rst)
        (last && !restart) |=> (cyc_q == '0));

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] slot_q [N_SLOTS];

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[i] <= '0;
            else if (wr_en && wr_idx == SLOT_W'(i))
                slot_q[i] <= wr_data;
        end

        a_r5_only_addressed_slot: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_idx == SLOT_W'(i)) |=> $stable(slot_q[i]));
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYC   = 32,
    parameter int SAMPLE_CYC = 12,
    parameter int SETTLE_CYC = 16,
    localparam int SET_W     = $clog2(SETTLE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              conv_sample,
    input  logic [BYTE_W-1:0] conv_data
);

    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] opt_q;
    logic [SET_W-1:0]  settle_q;
    logic              busy_q, done_q;
    logic [SLOT_W-1:0] slot_q;
    logic [BYTE_W-1:0] hold_q;
    logic              ctrl_wr, opt_wr, power, ready, start;
    logic              capture, last;
    logic [SLOT_W-1:0] rd_idx;
    logic [BYTE_W-1:0] slot_rdata;

    assign ctrl_wr = bus_wr && bus_addr == ADDR_CTRL;
    assign opt_wr  = bus_wr && bus_addr == ADDR_OPT;
    assign power   = opt_q[BYTE_W-1];
    assign ready   = settle_q == SET_W'(SETTLE_CYC);
    assign start   = ctrl_wr && power && ready;

    // option register and settling counter
    always_ff @(posedge clk) begin
        if (rst) begin
            opt_q    <= '0;
            settle_q <= '0;
        end else begin
            if (opt_wr)
                opt_q <= bus_wdata;
            if (!power || (opt_wr && !bus_wdata[BYTE_W-1]))
                settle_q <= '0;
            else if (!ready)
                settle_q <= settle_q + 1'b1;
        end
    end

    // group sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            slot_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(bus_wdata[5:0]);
            busy_q <= start;
            done_q <= 1'b0;
            slot_q <= '0;
        end else if (!power || (opt_wr && !bus_wdata[BYTE_W-1])) begin
            busy_q <= 1'b0;
        end else if (last) begin
            slot_q <= slot_q + 1'b1;
            if (slot_q == SLOT_W'(N_SLOTS - 1)) begin
                done_q <= 1'b1;
                busy_q <= ctrl_q.scan;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (capture)
            hold_q <= conv_data;
    end

    adc_conv_timer #(
        .CONV_CYC  (CONV_CYC),
        .SAMPLE_CYC(SAMPLE_CYC)
    ) i_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(ctrl_wr),
        .run    (busy_q),
        .sample (conv_sample),
        .capture(capture),
        .last   (last)
    );

    assign rd_idx = SLOT_W'(bus_addr - 3'd1);

    adc_result_bank i_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (last),
        .wr_idx (slot_q),
        .wr_data(hold_q),
        .rd_idx (rd_idx),
        .rd_data(slot_rdata)
    );

    assign conv_chan = pick_chan(ctrl_q, slot_q);

    always_comb begin
        case (bus_addr)
            ADDR_CTRL:               bus_rdata = {done_q, 1'b0, ctrl_q};
            3'd1, 3'd2, 3'd3, 3'd4:  bus_rdata = slot_rdata;
            ADDR_OPT:                bus_rdata = opt_q;
            default:                 bus_rdata = '0;
        endcase
    end

    a_r8_write_clears_done: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !done_q);

    a_r2_no_power_no_sample: assert property (@(posedge clk) disable iff (rst)
        !power |-> !conv_sample);

    a_r9_single_group_stops: assert property (@(posedge clk) disable iff (rst)
        ($rose(done_q) && !ctrl_q.scan) |-> !conv_sample);

    a_r7_chan_held_in_window: assert property (@(posedge clk) disable iff (rst)
        (conv_sample && $past(conv_sample) && !$past(ctrl_wr)) |-> $stable(conv_chan));

endmodule

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] conv_chan;
    logic       conv_sample;
    logic [7:0] conv_data;
    logic [7:0] vals [8];

    int checks = 0;
    int errors = 0;
    int samp_cnt = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign conv_data = vals[conv_chan];

    always @(posedge clk) if (conv_sample) samp_cnt++;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_chan(conv_chan),
        .conv_sample(conv_sample), .conv_data(conv_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5 d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // after a start write: done flag in cycle 127 then 128 (R6)
    task automatic check_done_edge(input string tag);
        logic [7:0] d;
        cycles(127);
        rd(3'd0, d);
        chk({tag, " R6 done low in cycle 127"}, d[7], 0);
        cycles(1);
        rd(3'd0, d);
        chk({tag, " R6 done high in cycle 128"}, d[7], 1);
    endtask

    task automatic check_slot(input string req, input int k, input int exp);
        logic [7:0] d;
        rd(3'(k), d);
        chk($sformatf("%s slot %0d", req, k), d, exp);
    endtask

    initial begin
        logic [7:0] d;
        int s0;
        for (int i = 0; i < 8; i++) vals[i] = 8'(i * 29 + 7);
        cycles(3);
        rst = 1'b0;
        cycles(1);

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk($sformatf("R1 addr %0d", a), d, 0);
        end

        // R2: unpowered write, then write during settling
        s0 = samp_cnt;
        wr(3'd0, 8'h01);
        cycles(200);
        rd(3'd0, d);
        chk("R2 done stays 0 without power", d[7], 0);
        chk("R2 no sampling without power", samp_cnt - s0, 0);
        check_slot("R2 slots untouched", 1, 0);
        wr(3'd5, 8'h80);
        wr(3'd0, 8'h02);
        cycles(150);
        rd(3'd0, d);
        chk("R2 done stays 0 when written during settling", d[7], 0);
        chk("R2 no sampling during settling", samp_cnt - s0, 0);
        check_slot("R2 slots untouched", 4, 0);

        // R3/R5/R6/R9/R11: single-channel sweep, bit 3 toggled
        for (int ch = 0; ch < 8; ch++) begin
            logic [7:0] cw;
            cw = {4'b0000, 1'(ch & 1), 3'(ch)};
            wr(3'd0, cw | 8'hC0);
            s0 = samp_cnt;
            rd(3'd0, d);
            chk("R11 readback ignores bits 7,6", d, cw);
            check_done_edge($sformatf("ch%0d", ch));
            chk("R7 48 sample cycles per group", samp_cnt - s0, 48);
            for (int k = 1; k <= 4; k++)
                check_slot($sformatf("R3 R5 ch%0d", ch), k, vals[ch]);
            s0 = samp_cnt;
            cycles(80);
            chk("R9 no sampling after single group", samp_cnt - s0, 0);
            rd(3'd0, d);
            chk("R9 R11 done stays set in readback", d, cw | 8'h80);
        end

        // R4/R5: bank mode, both banks, low select bits varied
        for (int b = 0; b < 2; b++) begin
            wr(3'd0, 8'h10 | 8'(b << 2) | 8'(b == 0 ? 3 : 1));
            check_done_edge($sformatf("bank%0d", b));
            for (int k = 1; k <= 4; k++)
                check_slot($sformatf("R4 R5 bank%0d", b), k, vals[b * 4 + k - 1]);
        end

        // R7: aperture edge on channel 2
        vals[2] = 8'd100;
        wr(3'd0, 8'h02);
        cycles(12);
        vals[2] = 8'd150;
        cycles(31);
        vals[2] = 8'd200;
        cycles(84);
        rd(3'd0, d);
        chk("R7 done low in cycle 127", d[7], 0);
        cycles(1);
        check_slot("R7 captured at end of window", 1, 100);
        check_slot("R7 captured in last window cycle", 2, 200);
        check_slot("R7 later conversion", 4, 200);

        // R8: abort a bank group, restart on channel 6
        wr(3'd0, 8'h10);
        cycles(50);
        rd(3'd0, d);
        chk("R8 done low mid-group", d[7], 0);
        wr(3'd0, 8'h06);
        check_done_edge("abort");
        for (int k = 1; k <= 4; k++)
            check_slot("R8 restarted group", k, vals[6]);

        // R10: continuous scan over bank 1
        wr(3'd0, 8'h34);
        check_done_edge("scan");
        vals[4] = 8'd77;
        s0 = samp_cnt;
        cycles(128);
        rd(3'd0, d);
        chk("R10 done stays 1", d[7], 1);
        chk("R10 sampling continues", samp_cnt - s0, 48);
        check_slot("R10 slot refreshed", 1, 77);
        check_slot("R10 slot order kept", 4, vals[7]);

        // R2: power off stops scanning
        wr(3'd5, 8'h00);
        s0 = samp_cnt;
        cycles(100);
        chk("R2 power off stops sampling", samp_cnt - s0, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule